// File: doc/BRIEF.md
# Dual-Master Bus Ownership Controller

This block decides which of two upstream masters drives a shared downstream two-wire bus. An upstream command decoder, outside the block, turns bus commands into single-cycle strobes: a request to take the bus, a clear for the lost-bus flag, and a configuration write that carries interrupt forwarding, interrupt masking and recovery enable. The block answers with one-hot connect enables for the two switch paths and one active-low interrupt line per master.

A master can take the bus whenever it asks, whatever the other master is doing. A failed or removed master therefore cannot hold the bus. The master that loses the bus receives a latched interrupt, and keeps it until it clears it. The downstream interrupt line is passed up to every master that has turned forwarding on. When recovery is enabled, a switch first disconnects both paths and starts an external recovery sequencer. The new path connects only after the sequencer reports that it is done. A parameter selects the reset owner: channel 0, or no channel.

Top module: `busown_ctrl`

## Requirements
- R1: After reset (rst_n low, asynchronous), with RST_OWNER=0 conn_o is 2'b01 and with RST_OWNER=-1 conn_o is 2'b00. Both int_n_o bits are 1 and rec_start_o is 0. Forwarding, masking and recovery enable are all cleared, so a later request switches at once.
- R2: At most one bit of conn_o is 1 in every cycle.
- R3: With recovery disabled, a take_req_i[k] pulse from a master that is not the owner makes conn_o equal to one-hot k (bit k set) at the clock edge that samples it. A request from the current owner changes nothing.
- R4: When several take_req_i bits are set in the same cycle, the lowest index wins and the other requests are ignored.
- R5: When conn_o[k] falls because the bus moved to another master, a lost flag for master k is set. The flag drives int_n_o[k] low until irq_clr_i[k] is sampled. A set and a clear in the same cycle leave the flag set. A master that takes the bus from no owner causes no lost flag.
- R6: int_n_o[k] is low in the same cycle that ds_int_n_i is low, provided master k's forwarding bit is 1. It rises as soon as ds_int_n_i rises, so nothing is latched.
- R7: While master k's mask bit is 1, int_n_o[k] stays 1. A lost flag set during the mask stays latched and shows once the mask is cleared. cfg_wr_i[k] loads fwd from cfg_fwd_i[k] and mask from cfg_mask_i[k] for master k. It also loads the global recovery enable from cfg_rec_i[k], and the lowest writing index wins.
- R8: With recovery enabled, a switch makes conn_o 2'b00 at the request edge and pulses rec_start_o for exactly one cycle. conn_o becomes one-hot of the target at the edge that samples rec_done_i. A rec_done_i with no switch pending is ignored.
- R9: A request sampled while a recovery is pending retargets the pending switch without a second rec_start_o pulse. The last target is connected on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_req_i | input | N_MST | Per-master take-ownership strobe |
| irq_clr_i | input | N_MST | Per-master clear of the lost-bus flag |
| cfg_wr_i | input | N_MST | Per-master configuration write strobe |
| cfg_fwd_i | input | N_MST | Forwarding enable loaded on cfg_wr_i |
| cfg_mask_i | input | N_MST | Interrupt mask loaded on cfg_wr_i |
| cfg_rec_i | input | N_MST | Recovery enable loaded on cfg_wr_i |
| ds_int_n_i | input | 1 | Downstream interrupt, active low |
| rec_done_i | input | 1 | Recovery sequencer completion pulse |
| conn_o | output | N_MST | One-hot switch path connect enables |
| int_n_o | output | N_MST | Per-master interrupt, active low |
| rec_start_o | output | 1 | One-cycle start pulse to the recovery sequencer |

## Verification
The bench builds two copies of the block with N_MST=2 and drives both from the same inputs. One copy uses RST_OWNER=0 and the other RST_OWNER=-1. The second copy shows the empty reset state. It also covers the first take-over from no owner, where no master may be told it lost the bus. Both copies then share a single ownership history, so the recovery, retarget and mid-run reset cases are checked under both reset variants.

// File: rtl/bo_pkg.sv
package bo_pkg;

   typedef enum logic [1:0] {
      OWN_IDLE  = 2'd0,
      OWN_LIVE  = 2'd1,
      OWN_RECOV = 2'd2
   } own_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bo_prio.sv
module bo_prio #(
   parameter int N_MST = 2,
   localparam int IW = bo_pkg::idx_width(N_MST)
) (
   input  logic [N_MST-1:0] req_i,
   output logic             vld_o,
   output logic [IW-1:0]    idx_o
);

   always_comb begin
      vld_o = 1'b0;
      idx_o = '0;
      for (int k = N_MST - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            vld_o = 1'b1;
            idx_o = IW'(k);
         end
      end
   end

endmodule

// File: rtl/bo_cfg.sv
module bo_cfg #(
   parameter int N_MST = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_MST-1:0] wr_i,
   input  logic [N_MST-1:0] fwd_i,
   input  logic [N_MST-1:0] mask_i,
   input  logic [N_MST-1:0] rec_i,
   output logic [N_MST-1:0] fwd_q,
   output logic [N_MST-1:0] mask_q,
   output logic             rec_en_q
);

   logic rec_nxt;

   for (genvar k = 0; k < N_MST; k++) begin : g_mst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fwd_q[k]  <= 1'b0;
            mask_q[k] <= 1'b0;
         end else if (wr_i[k]) begin
            fwd_q[k]  <= fwd_i[k];
            mask_q[k] <= mask_i[k];
         end
      end
   end

   always_comb begin
      rec_nxt = rec_en_q;
      for (int k = N_MST - 1; k >= 0; k--) begin
         if (wr_i[k]) begin
            rec_nxt = rec_i[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_en_q <= 1'b0;
      end else begin
         rec_en_q <= rec_nxt;
      end
   end

endmodule

// File: rtl/bo_owner.sv
module bo_owner #(
   parameter int N_MST     = 2,
   parameter int RST_OWNER = 0,
   localparam int IW = bo_pkg::idx_width(N_MST)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_vld_i,
   input  logic [IW-1:0]    win_idx_i,
   input  logic             rec_en_i,
   input  logic             rec_done_i,
   output logic [N_MST-1:0] conn_o,
   output logic [N_MST-1:0] lost_set_o,
   output logic             rec_start_o,
   output logic             busy_o
);

   import bo_pkg::*;

   localparam own_state_e RST_STATE = (RST_OWNER < 0) ? OWN_IDLE : OWN_LIVE;
   localparam logic [IW-1:0] RST_IDX = IW'((RST_OWNER < 0) ? 0 : RST_OWNER);

   if (RST_OWNER < -1 || RST_OWNER >= N_MST) begin : g_bad_rst
      $error("bo_owner: RST_OWNER must be -1 or a valid master index");
   end

   own_state_e       state_q, state_d;
   logic [IW-1:0]    cur_q, cur_d;
   logic             start_q, start_d;

   always_comb begin
      state_d    = state_q;
      cur_d      = cur_q;
      start_d    = 1'b0;
      lost_set_o = '0;
      case (state_q)
         OWN_IDLE, OWN_LIVE: begin
            if (win_vld_i && !(state_q == OWN_LIVE && win_idx_i == cur_q)) begin
               if (state_q == OWN_LIVE) begin
                  lost_set_o[cur_q] = 1'b1;
               end
               cur_d = win_idx_i;
               if (rec_en_i) begin
                  state_d = OWN_RECOV;
                  start_d = 1'b1;
               end else begin
                  state_d = OWN_LIVE;
               end
            end
         end
         OWN_RECOV: begin
            if (win_vld_i) begin
               cur_d = win_idx_i;
            end
            if (rec_done_i) begin
               state_d = OWN_LIVE;
            end
         end
         default: begin
            state_d = OWN_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RST_STATE;
         cur_q   <= RST_IDX;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cur_q   <= cur_d;
         start_q <= start_d;
      end
   end

   assign conn_o      = (state_q == OWN_LIVE) ? (N_MST'(1) << cur_q) : '0;
   assign rec_start_o = start_q;
   assign busy_o      = (state_q == OWN_RECOV);

endmodule

// File: rtl/bo_irq.sv
module bo_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic lost_set_i,
   input  logic clr_i,
   input  logic fwd_i,
   input  logic mask_i,
   input  logic ds_act_i,
   output logic lost_q,
   output logic int_n_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_q <= 1'b0;
      end else if (lost_set_i) begin
         lost_q <= 1'b1;
      end else if (clr_i) begin
         lost_q <= 1'b0;
      end
   end

   assign int_n_o = !(!mask_i && (lost_q || (fwd_i && ds_act_i)));

endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl #(
   parameter int N_MST     = 2,
   parameter int RST_OWNER = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_MST-1:0] take_req_i,
   input  logic [N_MST-1:0] irq_clr_i,
   input  logic [N_MST-1:0] cfg_wr_i,
   input  logic [N_MST-1:0] cfg_fwd_i,
   input  logic [N_MST-1:0] cfg_mask_i,
   input  logic [N_MST-1:0] cfg_rec_i,
   input  logic             ds_int_n_i,
   input  logic             rec_done_i,
   output logic [N_MST-1:0] conn_o,
   output logic [N_MST-1:0] int_n_o,
   output logic             rec_start_o
);

   localparam int IW = bo_pkg::idx_width(N_MST);

   if (N_MST < 2) begin : g_bad_n
      $error("busown_ctrl: N_MST must be at least 2");
   end

   logic             win_vld;
   logic [IW-1:0]    win_idx;
   logic [N_MST-1:0] fwd_q;
   logic [N_MST-1:0] mask_q;
   logic             rec_en_q;
   logic [N_MST-1:0] lost_set;
   logic [N_MST-1:0] lost_flag;
   logic             rec_busy;

   bo_prio #(.N_MST(N_MST)) u_prio (
      .req_i (take_req_i),
      .vld_o (win_vld),
      .idx_o (win_idx)
   );

   bo_cfg #(.N_MST(N_MST)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (cfg_wr_i),
      .fwd_i    (cfg_fwd_i),
      .mask_i   (cfg_mask_i),
      .rec_i    (cfg_rec_i),
      .fwd_q    (fwd_q),
      .mask_q   (mask_q),
      .rec_en_q (rec_en_q)
   );

   bo_owner #(.N_MST(N_MST), .RST_OWNER(RST_OWNER)) u_owner (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_vld_i   (win_vld),
      .win_idx_i   (win_idx),
      .rec_en_i    (rec_en_q),
      .rec_done_i  (rec_done_i),
      .conn_o      (conn_o),
      .lost_set_o  (lost_set),
      .rec_start_o (rec_start_o),
      .busy_o      (rec_busy)
   );

   for (genvar k = 0; k < N_MST; k++) begin : g_irq
      bo_irq u_irq (
         .clk        (clk),
         .rst_n      (rst_n),
         .lost_set_i (lost_set[k]),
         .clr_i      (irq_clr_i[k]),
         .fwd_i      (fwd_q[k]),
         .mask_i     (mask_q[k]),
         .ds_act_i   (!ds_int_n_i),
         .lost_q     (lost_flag[k]),
         .int_n_o    (int_n_o[k])
      );
   end

endmodule

// File: rtl/busown_checker.sv
module busown_checker #(
   parameter int N_MST = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_MST-1:0] take_req_i,
   input logic [N_MST-1:0] conn_o,
   input logic             rec_start_o,
   input logic [N_MST-1:0] lost_flag,
   input logic             rec_en_q,
   input logic             rec_busy
);

   AST_ONE_CONN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(conn_o)); // R2

   AST_START_DISCONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
      rec_start_o |-> (conn_o == '0)); // R8

   for (genvar k = 0; k < N_MST; k++) begin : g_chk
      localparam logic [N_MST-1:0] LOWER = N_MST'((1 << k) - 1);

      AST_LOST_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(conn_o[k]) |-> lost_flag[k]); // R5

      AST_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
         (take_req_i[k] && ((take_req_i & LOWER) == '0) && !rec_en_q && !rec_busy)
         |=> conn_o[k]); // R4
   end

endmodule

bind busown_ctrl busown_checker #(.N_MST(N_MST)) u_busown_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .take_req_i  (take_req_i),
   .conn_o      (conn_o),
   .rec_start_o (rec_start_o),
   .lost_flag   (lost_flag),
   .rec_en_q    (rec_en_q),
   .rec_busy    (rec_busy)
);

// File: tb/test_busown_ctrl.sv
module test_busown_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] take_req = '0;
   logic [N-1:0] irq_clr = '0;
   logic [N-1:0] cfg_wr = '0;
   logic [N-1:0] cfg_fwd = '0;
   logic [N-1:0] cfg_mask = '0;
   logic [N-1:0] cfg_rec = '0;
   logic         ds_int_n = 1'b1;
   logic         rec_done = 1'b0;
   logic [N-1:0] conn_a, int_a, conn_b, int_b;
   logic         start_a, start_b;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   busown_ctrl #(.N_MST(N), .RST_OWNER(0)) i_busown_ctrl (
      .clk(clk), .rst_n(rst_n), .take_req_i(take_req), .irq_clr_i(irq_clr),
      .cfg_wr_i(cfg_wr), .cfg_fwd_i(cfg_fwd), .cfg_mask_i(cfg_mask),
      .cfg_rec_i(cfg_rec), .ds_int_n_i(ds_int_n), .rec_done_i(rec_done),
      .conn_o(conn_a), .int_n_o(int_a), .rec_start_o(start_a)
   );

   busown_ctrl #(.N_MST(N), .RST_OWNER(-1)) i_busown_ctrl_none (
      .clk(clk), .rst_n(rst_n), .take_req_i(take_req), .irq_clr_i(irq_clr),
      .cfg_wr_i(cfg_wr), .cfg_fwd_i(cfg_fwd), .cfg_mask_i(cfg_mask),
      .cfg_rec_i(cfg_rec), .ds_int_n_i(ds_int_n), .rec_done_i(rec_done),
      .conn_o(conn_b), .int_n_o(int_b), .rec_start_o(start_b)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_req(input logic [N-1:0] v);
      take_req = v;
      tick();
      take_req = '0;
   endtask

   task automatic clear_irq(input logic [N-1:0] v);
      irq_clr = v;
      tick();
      irq_clr = '0;
   endtask

   task automatic write_cfg(input logic [N-1:0] wr, input logic [N-1:0] fwd,
                            input logic [N-1:0] mask, input logic [N-1:0] rec);
      cfg_wr = wr; cfg_fwd = fwd; cfg_mask = mask; cfg_rec = rec;
      tick();
      cfg_wr = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 reset conn ch0 variant", 4'(conn_a), 4'b01);
      check("R1 reset conn none variant", 4'(conn_b), 4'b00);
      check("R1 reset int ch0 variant", 4'(int_a), 4'b11);
      check("R1 reset int none variant", 4'(int_b), 4'b11);
      check("R1 reset rec_start", 4'({start_a, start_b}), 4'b00);
   endtask

   task automatic t_direct();
      pulse_req(2'b10);
      check("R3 switch to master1", 4'(conn_a), 4'b10);
      check("R5 master0 told of loss", 4'(int_a), 4'b10);
      check("R3 take from no owner", 4'(conn_b), 4'b10);
      check("R5 no loss from no owner", 4'(int_b), 4'b11);
      tick(); tick(); tick();
      check("R5 loss flag held", 4'(int_a), 4'b10);
      pulse_req(2'b10);
      check("R3 owner request no change", 4'(conn_a), 4'b10);
      check("R3 owner request no new irq", 4'(int_b), 4'b11);
      clear_irq(2'b01);
      check("R5 clear strobe", 4'(int_a), 4'b11);
   endtask

   task automatic t_tie();
      pulse_req(2'b11);
      check("R4 lowest index wins", 4'(conn_a), 4'b01);
      check("R4 lowest index wins none variant", 4'(conn_b), 4'b01);
      check("R5 master1 told of loss", 4'(int_a), 4'b01);
      clear_irq(2'b10);
      check("R5 clear master1", 4'(int_a), 4'b11);
   endtask

   task automatic t_set_beats_clear();
      take_req = 2'b10;
      irq_clr = 2'b01;
      tick();
      take_req = '0;
      irq_clr = '0;
      check("R5 set beats clear", 4'(int_a), 4'b10);
      clear_irq(2'b01);
      check("R5 cleared after", 4'(int_a), 4'b11);
   endtask

   task automatic t_forward();
      write_cfg(2'b11, 2'b01, 2'b00, 2'b00);
      ds_int_n = 1'b0;
      #1;
      check("R6 forward to master0 only", 4'(int_a), 4'b10);
      ds_int_n = 1'b1;
      #1;
      check("R6 forward follows level", 4'(int_a), 4'b11);
   endtask

   task automatic t_mask();
      write_cfg(2'b11, 2'b11, 2'b01, 2'b00);
      ds_int_n = 1'b0;
      #1;
      check("R7 mask blocks forward", 4'(int_a), 4'b01);
      ds_int_n = 1'b1;
      write_cfg(2'b11, 2'b00, 2'b10, 2'b00);
      pulse_req(2'b01);
      check("R3 switch back to master0", 4'(conn_a), 4'b01);
      check("R7 masked loss hidden", 4'(int_a), 4'b11);
      write_cfg(2'b10, 2'b00, 2'b00, 2'b00);
      check("R7 latched loss shows after unmask", 4'(int_a), 4'b01);
      clear_irq(2'b10);
      check("R7 cleared", 4'(int_a), 4'b11);
   endtask

   task automatic t_recovery();
      write_cfg(2'b01, 2'b00, 2'b00, 2'b01);
      pulse_req(2'b10);
      check("R8 disconnect during recovery", 4'(conn_a), 4'b00);
      check("R8 start pulse", 4'(start_a), 4'b1);
      check("R5 loss at recovery switch", 4'(int_a), 4'b10);
      tick();
      check("R8 start pulse one cycle", 4'(start_a), 4'b0);
      tick(); tick();
      check("R8 still disconnected", 4'(conn_a), 4'b00);
      rec_done = 1'b1;
      tick();
      rec_done = 1'b0;
      check("R8 connect on done", 4'(conn_a), 4'b10);
      check("R8 connect on done none variant", 4'(conn_b), 4'b10);
      clear_irq(2'b01);
   endtask

   task automatic t_retarget();
      pulse_req(2'b01);
      check("R9 disconnect", 4'(conn_a), 4'b00);
      check("R9 start", 4'(start_a), 4'b1);
      tick();
      pulse_req(2'b10);
      check("R9 no second start", 4'(start_a), 4'b0);
      check("R9 still disconnected", 4'(conn_a), 4'b00);
      rec_done = 1'b1;
      tick();
      rec_done = 1'b0;
      check("R9 retargeted connect", 4'(conn_a), 4'b10);
      clear_irq(2'b10);
      check("R9 irq cleared", 4'(int_a), 4'b11);
   endtask

   task automatic t_stray_done();
      rec_done = 1'b1;
      tick();
      rec_done = 1'b0;
      check("R8 stray done ignored", 4'(conn_a), 4'b10);
      check("R8 stray done no start", 4'(start_a), 4'b0);
   endtask

   task automatic t_mid_reset();
      do_reset();
      check("R1 mid-run reset conn", 4'(conn_a), 4'b01);
      check("R1 mid-run reset int", 4'(int_a), 4'b11);
      pulse_req(2'b10);
      check("R1 recovery cleared by reset", 4'(conn_a), 4'b10);
      check("R1 no start after reset", 4'(start_a), 4'b0);
      check("R1 none variant after reset", 4'(conn_b), 4'b10);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_direct();
      t_tie();
      t_set_beats_clear();
      t_forward();
      t_mask();
      t_recovery();
      t_retarget();
      t_stray_done();
      t_mid_reset();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule